// File: doc/BRIEF.md
# Periodic Wake Watchdog Sequencer

This block wakes a sleeping microcontroller at a fixed period and watches for its acknowledgement. It runs on the system clock but advances its timers only on a slow tick strobe of roughly 10 ms. Once per programmed interval it raises a short wake pulse. The microcontroller must answer with a rising edge on its acknowledge line early enough in the interval. If no answer comes, the block drives its active-low reset output instead of the next wake pulse. After that reset pulse it restarts the interval timing.

At power-on the reset output is held low through a resistor-reading phase and then through one reset pulse width. The interval length (a tick count) is captured once, when the reading phase ends. The first interval after any reset is not supervised and carries no opening wake pulse. A separate manual-reset detector can request a synchronous clear at any time. A clear forces both outputs to their reset values and zeroes the counters.

Top module: `wake_watchdog_top`

## Requirements
- R1: After an acknowledged interval, the next interval opens with a wake pulse that starts on a tick and stays high for exactly WAKE_TICKS ticks. Outside such pulses `wakeOut` is low.
- R2: After `rstN` is released, `rstOutN` stays low for STARTUP_TICKS + RST_TICKS ticks and `wakeOut` stays low. The first interval that follows has no opening wake pulse. At its end a wake pulse is issued whether or not an acknowledge arrived.
- R3: An acknowledge is a low-to-high transition of `doneIn`, seen after two synchronizer flops. Only the first such edge in an interval is taken, and later edges in that interval have no effect.
- R4: An edge is accepted only while the interval's tick count is below interval − GUARD_TICKS. An edge in the last GUARD_TICKS ticks of the interval counts as missing.
- R5: An accepted acknowledge that arrives while `wakeOut` is high drives `wakeOut` low on the next clock.
- R6: At the end of an interval with no accepted acknowledge, `rstOutN` goes low for RST_TICKS ticks and no wake pulse is issued. An unsupervised interval follows, so the next wake rises RST_TICKS + interval ticks after the reset falls.
- R7: `intervalTicks` is sampled only when the reading phase ends. Later changes to it do not alter the period.
- R8: A sampled interval below WAKE_TICKS + GUARD_TICKS + 1 is raised to that floor.
- R9: While `clearReq` is high outside the reading phase, `wakeOut` and `rstOutN` are low from the next clock and the counters hold at zero. After release, `rstOutN` stays low for RST_TICKS ticks, and then an unsupervised interval follows.
- R10: A clear during the reading phase restarts the full reading phase once `clearReq` is released.
- R11: An acknowledge does not restart the interval count. Wake pulses keep their period whenever the acknowledge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| tickEn | input | 1 | One-clock strobe per slow tick |
| clearReq | input | 1 | Synchronous clear from the manual-reset detector |
| intervalTicks | input | IV_W | Programmed interval length in ticks |
| doneIn | input | 1 | Acknowledge from the microcontroller, asynchronous |
| wakeOut | output | 1 | Wake pulse, active high |
| rstOutN | output | 1 | Reset to the microcontroller, active low |

## Verification
The in-line assertions check the properties that hold on every clock. A wake pulse never overlaps reset. A wake pulse only starts on a tick. A clear forces both outputs low on the next clock. The synchronized edge lasts one clock, an accepted edge ends a wake pulse at once, an edge in the guard window never sets the acknowledge flag, and the latched interval never falls below its floor. The bench scenarios cover the sequence-level behaviour:
- the startup and reset-pulse durations;
- the unsupervised first interval;
- the exact guard boundary and a late edge that leads to reset;
- the recovery period after a miss;
- latch-once interval capture and clamping;
- a clear applied during the reading phase.

// File: rtl/wake_watchdog_pkg.sv
package wake_watchdog_pkg;

  typedef enum logic [1:0] {
    ST_READ = 2'd0,
    ST_RSTP = 2'd1,
    ST_RUN  = 2'd2
  } seqState_t;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic ivLatch;
  } dpCtrl_t;

  typedef struct packed {
    logic doneRise;
    logic atStartEnd;
    logic atRstEnd;
    logic atIvEnd;
    logic atWakeEnd;
    logic lateWin;
  } dpFlags_t;

endpackage

// File: rtl/wake_watchdog_dp.sv
module wake_watchdog_dp
  import wake_watchdog_pkg::*;
#(
  parameter int IV_W          = 16,
  parameter int STARTUP_TICKS = 10,
  parameter int RST_TICKS     = 32,
  parameter int WAKE_TICKS    = 2,
  parameter int GUARD_TICKS   = 2,
  parameter int SYNC_STAGES   = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpCtrl_t         ctl,
  input  logic [IV_W-1:0] intervalTicks,
  input  logic            doneIn,
  output dpFlags_t        flags
);

  localparam int MIN_IV = WAKE_TICKS + GUARD_TICKS + 1;
  localparam int W_ST   = $clog2(STARTUP_TICKS + 1);
  localparam int W_RS   = $clog2(RST_TICKS + 1);
  localparam int W_A    = (W_ST > W_RS) ? W_ST : W_RS;
  localparam int CNT_W  = (W_A > IV_W) ? W_A : IV_W;
  localparam logic [CNT_W-1:0] START_LAST = CNT_W'(STARTUP_TICKS - 1);
  localparam logic [CNT_W-1:0] RST_LAST   = CNT_W'(RST_TICKS - 1);
  localparam logic [CNT_W-1:0] WAKE_LAST  = CNT_W'(WAKE_TICKS - 1);
  localparam logic [CNT_W-1:0] GUARD_C    = CNT_W'(GUARD_TICKS);
  localparam logic [IV_W-1:0]  MIN_IV_C   = IV_W'(MIN_IV);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic [CNT_W-1:0]       cntQ;
  logic [IV_W-1:0]        ivQ;
  logic [CNT_W-1:0]       ivWide;

  // acknowledge synchronizer chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], doneIn};
      prevQ <= syncQ[SYNC_STAGES-1];
    end
  end

  // shared phase / interval counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cntQ <= '0;
    else if (ctl.cntClr) cntQ <= '0;
    else if (ctl.cntInc) cntQ <= cntQ + 1'b1;
  end

  // interval capture with floor
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ivQ <= MIN_IV_C;
    else if (ctl.ivLatch)
      ivQ <= (intervalTicks < MIN_IV_C) ? MIN_IV_C : intervalTicks;
  end

  assign ivWide = CNT_W'(ivQ);

  always_comb begin
    flags.doneRise   = syncQ[SYNC_STAGES-1] & ~prevQ;
    flags.atStartEnd = (cntQ == START_LAST);
    flags.atRstEnd   = (cntQ == RST_LAST);
    flags.atIvEnd    = (cntQ == ivWide - 1'b1);
    flags.atWakeEnd  = (cntQ == WAKE_LAST);
    flags.lateWin    = (cntQ >= ivWide - GUARD_C);
  end

  AST_EDGE_ONE_CLK: assert property (@(posedge clk) disable iff (!rstN)
    flags.doneRise |=> !flags.doneRise); // R3
  AST_IV_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    ivQ >= MIN_IV_C); // R8

endmodule

// File: rtl/wake_watchdog_ctl.sv
module wake_watchdog_ctl
  import wake_watchdog_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     tickEn,
  input  logic     clearReq,
  input  dpFlags_t flags,
  output dpCtrl_t  ctl,
  output logic     wakeOut,
  output logic     rstOutN
);

  seqState_t stateQ;
  logic      wakeQ;
  logic      ackQ;
  logic      firstQ;
  logic      phaseEnd;

  always_comb begin
    unique case (stateQ)
      ST_READ: phaseEnd = flags.atStartEnd;
      ST_RSTP: phaseEnd = flags.atRstEnd;
      default: phaseEnd = flags.atIvEnd;
    endcase
    ctl.cntClr  = clearReq | (tickEn & phaseEnd);
    ctl.cntInc  = tickEn & ~ctl.cntClr;
    ctl.ivLatch = ~clearReq & tickEn & (stateQ == ST_READ) & flags.atStartEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_READ;
      wakeQ  <= 1'b0;
      ackQ   <= 1'b0;
      firstQ <= 1'b1;
    end else if (clearReq) begin
      stateQ <= (stateQ == ST_READ) ? ST_READ : ST_RSTP;
      wakeQ  <= 1'b0;
      ackQ   <= 1'b0;
      firstQ <= 1'b1;
    end else begin
      unique case (stateQ)
        ST_READ: if (tickEn && flags.atStartEnd) stateQ <= ST_RSTP;
        ST_RSTP: if (tickEn && flags.atRstEnd) begin
          stateQ <= ST_RUN;
          firstQ <= 1'b1;
        end
        default: begin
          if (tickEn && flags.atIvEnd) begin
            ackQ <= 1'b0;
            if (firstQ || ackQ) begin
              wakeQ  <= 1'b1;
              firstQ <= 1'b0;
            end else begin
              stateQ <= ST_RSTP;
              wakeQ  <= 1'b0;
              firstQ <= 1'b1;
            end
          end else begin
            if (tickEn && wakeQ && flags.atWakeEnd) wakeQ <= 1'b0;
            if (flags.doneRise && !ackQ && !flags.lateWin) begin
              ackQ  <= 1'b1;
              wakeQ <= 1'b0;
            end
          end
        end
      endcase
    end
  end

  assign wakeOut = wakeQ;
  assign rstOutN = (stateQ == ST_RUN);

  AST_WAKE_NOT_IN_RESET: assert property (@(posedge clk) disable iff (!rstN)
    wakeOut |-> rstOutN); // R1
  AST_WAKE_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeOut) |-> $past(tickEn)); // R1
  AST_CLEAR_FORCES: assert property (@(posedge clk) disable iff (!rstN)
    clearReq |=> (!wakeOut && !rstOutN)); // R9
  AST_EARLY_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (wakeOut && flags.doneRise && !clearReq) |=> !wakeOut); // R5
  AST_GUARD_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RUN && flags.doneRise && flags.lateWin && !ackQ) |=> !ackQ); // R4

endmodule

// File: rtl/wake_watchdog_top.sv
module wake_watchdog_top
  import wake_watchdog_pkg::*;
#(
  parameter int IV_W          = 16,
  parameter int STARTUP_TICKS = 10,
  parameter int RST_TICKS     = 32,
  parameter int WAKE_TICKS    = 2,
  parameter int GUARD_TICKS   = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            tickEn,
  input  logic            clearReq,
  input  logic [IV_W-1:0] intervalTicks,
  input  logic            doneIn,
  output logic            wakeOut,
  output logic            rstOutN
);

  dpCtrl_t  ctl;
  dpFlags_t flags;

  wake_watchdog_dp #(
    .IV_W(IV_W), .STARTUP_TICKS(STARTUP_TICKS), .RST_TICKS(RST_TICKS),
    .WAKE_TICKS(WAKE_TICKS), .GUARD_TICKS(GUARD_TICKS), .SYNC_STAGES(2)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .intervalTicks(intervalTicks),
    .doneIn(doneIn), .flags(flags)
  );

  wake_watchdog_ctl ctl_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .clearReq(clearReq),
    .flags(flags), .ctl(ctl), .wakeOut(wakeOut), .rstOutN(rstOutN)
  );

endmodule

// File: tb/wake_watchdog_top_tb_top.sv
module wake_watchdog_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        clearReq = 1'b0;
  logic [15:0] intervalTicks = 16'd10;
  logic        doneIn = 1'b0;
  logic        wakeOut;
  logic        rstOutN;
  int          nChecks = 0;
  int          nFails = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  wake_watchdog_top #(
    .IV_W(16), .STARTUP_TICKS(4), .RST_TICKS(6), .WAKE_TICKS(2), .GUARD_TICKS(2)
  ) dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .clearReq(clearReq),
    .intervalTicks(intervalTicks), .doneIn(doneIn),
    .wakeOut(wakeOut), .rstOutN(rstOutN)
  );

  // slow tick: one clock in four
  initial begin
    forever begin
      repeat (3) @(negedge clk);
      tickEn = 1'b1;
      @(negedge clk);
      tickEn = 1'b0;
    end
  end

  task automatic chk(string req, logic act, logic exp, string what);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic waitTicks(int n);
    for (int i = 0; i < n; i++) begin
      do @(posedge clk); while (tickEn !== 1'b1);
      @(negedge clk);
    end
  endtask

  task automatic pulseDone();
    doneIn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    doneIn = 1'b0;
    @(negedge clk);
  endtask

  task automatic powerOn(logic [15:0] iv);
    rstN = 1'b0;
    intervalTicks = iv;
    waitTicks(1);
    rstN = 1'b1;
  endtask

  task automatic testResetState();
    chk("R2", rstOutN, 1'b0, "rstOutN after reset");
    chk("R2", wakeOut, 1'b0, "wakeOut after reset");
  endtask

  task automatic testStartup();
    waitTicks(9);
    chk("R2", rstOutN, 1'b0, "reset still low at tick 9");
    waitTicks(1);
    chk("R2", rstOutN, 1'b1, "reset released at tick 10");
    chk("R2", wakeOut, 1'b0, "no wake at first interval start");
  endtask

  task automatic testFirstInterval();
    waitTicks(9);
    chk("R2", wakeOut, 1'b0, "no wake inside first interval");
    waitTicks(1);
    chk("R2", wakeOut, 1'b1, "wake after unsupervised interval");
  endtask

  task automatic testEarlyDone();
    waitTicks(1);
    chk("R1", wakeOut, 1'b1, "wake still high one tick in");
    pulseDone();
    chk("R5", wakeOut, 1'b0, "wake cut short by acknowledge");
  endtask

  task automatic testPeriodKept();
    waitTicks(7);
    pulseDone();
    waitTicks(1);
    chk("R3", wakeOut, 1'b0, "second edge leaves wake low");
    waitTicks(1);
    chk("R11", wakeOut, 1'b1, "wake period unchanged by acknowledge");
    chk("R3", rstOutN, 1'b1, "acknowledged interval gives no reset");
    waitTicks(1);
    chk("R1", wakeOut, 1'b1, "wake high second tick");
    waitTicks(1);
    chk("R1", wakeOut, 1'b0, "wake ends after two ticks");
  endtask

  task automatic testLateDone();
    waitTicks(6);
    pulseDone();
    waitTicks(1);
    chk("R4", rstOutN, 1'b1, "no reset before boundary");
    waitTicks(1);
    chk("R4", rstOutN, 1'b0, "late acknowledge counts as missed");
    chk("R6", wakeOut, 1'b0, "no wake with reset");
  endtask

  task automatic testMissRecovery();
    waitTicks(5);
    chk("R6", rstOutN, 1'b0, "reset pulse still low");
    waitTicks(1);
    chk("R6", rstOutN, 1'b1, "reset pulse six ticks");
    waitTicks(9);
    chk("R6", wakeOut, 1'b0, "no wake in interval after reset");
    waitTicks(1);
    chk("R6", wakeOut, 1'b1, "wake reset width plus interval later");
  endtask

  task automatic testGuardEdge();
    waitTicks(7);
    intervalTicks = 16'd20;
    pulseDone();
    waitTicks(3);
    chk("R4", wakeOut, 1'b1, "edge at last accepted tick is taken");
    chk("R4", rstOutN, 1'b1, "no reset after boundary acknowledge");
  endtask

  task automatic testClearRun();
    waitTicks(2);
    clearReq = 1'b1;
    @(negedge clk);
    chk("R9", rstOutN, 1'b0, "clear drives reset low");
    chk("R9", wakeOut, 1'b0, "clear drives wake low");
    waitTicks(2);
    clearReq = 1'b0;
    waitTicks(5);
    chk("R9", rstOutN, 1'b0, "reset held after clear release");
    waitTicks(1);
    chk("R9", rstOutN, 1'b1, "reset ends after reset width");
    waitTicks(9);
    chk("R7", wakeOut, 1'b0, "no wake before original interval");
    waitTicks(1);
    chk("R7", wakeOut, 1'b1, "interval still the latched value");
  endtask

  task automatic testClearInRead();
    powerOn(16'd3);
    waitTicks(2);
    clearReq = 1'b1;
    waitTicks(2);
    clearReq = 1'b0;
    waitTicks(9);
    chk("R10", rstOutN, 1'b0, "reading restarted after clear");
    waitTicks(1);
    chk("R10", rstOutN, 1'b1, "reset released after full restart");
    waitTicks(4);
    chk("R8", wakeOut, 1'b0, "clamped interval not yet done");
    waitTicks(1);
    chk("R8", wakeOut, 1'b1, "short interval raised to floor");
  endtask

  initial begin
    powerOn(16'd10);
    testResetState();
    testStartup();
    testFirstInterval();
    testEarlyDone();
    testPeriodKept();
    testLateDone();
    testMissRecovery();
    testGuardEdge();
    testClearRun();
    testClearInRead();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule